// File: doc/BRIEF.md
# Indirect LPC Access Engine

This block lets a host reach a narrow downstream peripheral bus through a small window of 64-bit registers on a control bus. The host selects a register with a byte address whose value shifted right by three gives the register word offset. It writes a command word holding a direction flag, a 32-bit target address and a byte count. Writing a read command starts the downstream read at once, and the result lands in the data register. Writing the data register while the stored command is a write sends that data downstream.

Data is exchanged at its natural big-endian position inside an 8-byte aligned sector. The first byte of a transfer sits in the byte lane selected by the low three address bits, with lane 0 the most significant byte of the 64-bit register. It is not right-justified. A status register shows a done flag that drops while a transfer is in flight. Host writes that arrive during a transfer are stored but do not start a second one.

Top module: `lpc_indirect_eng`

## Requirements
- R1: Register word offset is `cb_addr >> 3`. 0x40 holds the base register, 0x41 the command, 0x42 the data and 0x43 the status. After reset the command and data registers read zero. The base register and every unmapped offset read zero, and writes to them are ignored.
- R2: Command bits are numbered from the MSB, so bit 0 is vector bit 63. Vector bit 63 set means read and clear means write. Vector bits [58:52] hold the byte count, and [31:0] hold the target address. The command register reads back exactly as written.
- R3: A command write with bit 63 set and a legal size issues exactly one downstream read request. The request is visible in the cycle after the write, with `ds_req_write`=0, the command's address and its size.
- R4: A data-register write while the stored command has bit 63 clear issues one downstream write request in the next cycle, carrying the command's address and size. A command write with bit 63 clear starts nothing. A data write while the command is a read starts nothing, and the data register reads back the written value.
- R5: Read placement: the N response bytes (right-justified in `ds_rsp_rdata`, first byte most significant) are stored into the data register. Byte k of the transfer goes to lane addr[2:0]+k, where lane 0 is bits [63:56]. All other lanes are zero, and bytes that would pass lane 7 are dropped.
- R6: Write extraction: `ds_req_wdata` carries the N bytes taken from lanes addr[2:0]..addr[2:0]+N-1 of the data register. They are right-justified with the first byte most significant, and lanes past 7 give zero. `ds_req_be` has its low N bits set.
- R7: Status bit 63 reads 1 when idle. It reads 0 from the cycle after a launch until the edge that samples `ds_rsp_valid`. The remaining status bits read zero, and status writes are ignored.
- R8: A command or data write while a transfer is outstanding updates that register but launches no further request. A read response still overwrites the data register.
- R9: Only sizes 1, 2 and 4 bytes are legal. A command with any other size launches nothing, leaves done at 1 and leaves the data register unchanged.
- R10: A request keeps `ds_req_valid` high, with address, size, direction, data and enables stable, until the cycle in which `ds_req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cb_valid | input | 1 | Control-bus access strobe |
| cb_we | input | 1 | Control-bus write (1) or read (0) |
| cb_addr | input | CB_ADDR_W | Control-bus byte address |
| cb_wdata | input | 64 | Control-bus write data |
| cb_rdata | output | 64 | Control-bus read data, combinational from `cb_addr` |
| ds_req_valid | output | 1 | Downstream request valid |
| ds_req_ready | input | 1 | Downstream request accepted |
| ds_req_write | output | 1 | Request direction, 1 = write |
| ds_req_addr | output | DS_ADDR_W | Request byte address |
| ds_req_size | output | SZ_W | Request byte count (1, 2 or 4) |
| ds_req_wdata | output | DS_DATA_W | Write bytes, right-justified |
| ds_req_be | output | DS_DATA_W/8 | Byte enables, low N bits set |
| ds_rsp_valid | input | 1 | Downstream response strobe |
| ds_rsp_rdata | input | DS_DATA_W | Read response bytes, right-justified |

## Verification
Control-bus reads are combinational, so the bench samples `cb_rdata` 1 ns after setting the address, in the low phase of the clock. A launching register write takes effect at the next rising edge. The bench therefore checks the request fields and the cleared done bit at the following falling edge, and holds `ds_req_ready` low for random cycles to confirm the request stays stable. The response is driven for a single edge. The data register and the done bit are checked at the falling edge after that edge, and a few more idle cycles confirm that no second request appears after writes made while busy.

// File: rtl/lpce_pkg.sv
package lpce_pkg;
   localparam int REG_W        = 64;
   localparam int SECTOR_BYTES = 8;
   localparam int SIZE_FLD_W   = 7;

   typedef enum logic [1:0] {
      XF_IDLE = 2'd0,
      XF_REQ  = 2'd1,
      XF_WAIT = 2'd2
   } xfer_state_e;

   typedef struct packed {
      logic                  is_read;
      logic [SIZE_FLD_W-1:0] size;
      logic [31:0]           addr;
   } cmd_fields_t;
endpackage

// File: rtl/lpce_cmd_decode.sv
module lpce_cmd_decode
   import lpce_pkg::*;
#(
   parameter int MAX_BYTES = 4
) (
   input  logic [REG_W-1:0] cmd_word,
   output cmd_fields_t      fields,
   output logic             size_ok
);
   logic unused_cmd;

   // MSB-first numbering: bit 0 -> [63], bits 5..11 -> [58:52], bits 32..63 -> [31:0]
   assign fields.is_read = cmd_word[63];
   assign fields.size    = cmd_word[58:52];
   assign fields.addr    = cmd_word[31:0];
   assign unused_cmd     = ^{cmd_word[62:59], cmd_word[51:32]};

   // legal sizes: nonzero power of two no wider than the downstream bus
   assign size_ok = (fields.size != '0)
                 && (fields.size <= SIZE_FLD_W'(MAX_BYTES))
                 && ((fields.size & (fields.size - 7'd1)) == '0);
endmodule

// File: rtl/lpce_lane_align.sv
module lpce_lane_align
   import lpce_pkg::*;
#(
   parameter int DS_DATA_W = 32,
   localparam int NB       = DS_DATA_W / 8
) (
   input  logic [DS_DATA_W-1:0]  rd_src,
   input  logic [SIZE_FLD_W-1:0] rd_size,
   input  logic [2:0]            rd_off,
   output logic [REG_W-1:0]      rd_placed,
   input  logic [REG_W-1:0]      wr_src,
   input  logic [SIZE_FLD_W-1:0] wr_size,
   input  logic [2:0]            wr_off,
   output logic [DS_DATA_W-1:0]  wr_bytes,
   output logic [NB-1:0]         wr_be
);
   // read side: one selector per sector lane, lane 0 = most significant byte
   for (genvar j = 0; j < SECTOR_BYTES; j++) begin : g_lane
      logic [7:0] lane_b;
      always_comb begin
         lane_b = 8'h00;
         for (int k = 0; k < NB; k++) begin
            if ((k < int'(rd_size)) && (int'(rd_off) + k == j)) begin
               lane_b = 8'(rd_src >> (8 * (int'(rd_size) - 1 - k)));
            end
         end
      end
      assign rd_placed[REG_W-1-8*j -: 8] = lane_b;
   end

   // write side: byte position p (0 = least significant) carries transfer byte size-1-p
   always_comb begin
      wr_bytes = '0;
      wr_be    = '0;
      for (int p = 0; p < NB; p++) begin
         if (p < int'(wr_size)) begin
            wr_be[p] = 1'b1;
            if (int'(wr_off) + int'(wr_size) - 1 - p < SECTOR_BYTES) begin
               wr_bytes[8*p +: 8] = 8'(wr_src >>
                  (8 * (SECTOR_BYTES - 1 - (int'(wr_off) + int'(wr_size) - 1 - p))));
            end
         end
      end
   end
endmodule

// File: rtl/lpce_xfer_fsm.sv
module lpce_xfer_fsm
   import lpce_pkg::*;
#(
   parameter int DS_ADDR_W = 32,
   parameter int DS_DATA_W = 32,
   parameter int SZ_W      = 3,
   localparam int NB       = DS_DATA_W / 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 launch,
   input  logic                 launch_write,
   input  logic [DS_ADDR_W-1:0] launch_addr,
   input  logic [SZ_W-1:0]      launch_size,
   input  logic [DS_DATA_W-1:0] launch_wdata,
   input  logic [NB-1:0]        launch_be,
   output logic                 req_valid,
   input  logic                 req_ready,
   output logic                 req_write,
   output logic [DS_ADDR_W-1:0] req_addr,
   output logic [SZ_W-1:0]      req_size,
   output logic [DS_DATA_W-1:0] req_wdata,
   output logic [NB-1:0]        req_be,
   input  logic                 rsp_valid,
   output logic                 busy,
   output logic                 rd_done
);
   xfer_state_e state_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q   <= XF_IDLE;
         req_write <= 1'b0;
         req_addr  <= '0;
         req_size  <= '0;
         req_wdata <= '0;
         req_be    <= '0;
      end else begin
         unique case (state_q)
            XF_IDLE: if (launch) begin
               state_q   <= XF_REQ;
               req_write <= launch_write;
               req_addr  <= launch_addr;
               req_size  <= launch_size;
               req_wdata <= launch_write ? launch_wdata : '0;
               req_be    <= launch_be;
            end
            XF_REQ:  if (req_ready) state_q <= XF_WAIT;
            XF_WAIT: if (rsp_valid) state_q <= XF_IDLE;
            default: state_q <= XF_IDLE;
         endcase
      end
   end

   assign req_valid = (state_q == XF_REQ);
   assign busy      = (state_q != XF_IDLE);
   assign rd_done   = (state_q == XF_WAIT) && rsp_valid && !req_write;
endmodule

// File: rtl/lpc_indirect_eng.sv
module lpc_indirect_eng
   import lpce_pkg::*;
#(
   parameter int CB_ADDR_W = 16,
   parameter int DS_ADDR_W = 32,
   parameter int DS_DATA_W = 32,
   parameter int OFS_BASE  = 'h40,
   parameter int OFS_CMD   = 'h41,
   parameter int OFS_DATA  = 'h42,
   parameter int OFS_STAT  = 'h43,
   localparam int NB       = DS_DATA_W / 8,
   localparam int SZ_W     = $clog2(NB) + 1,
   localparam int OW       = CB_ADDR_W - 3
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 cb_valid,
   input  logic                 cb_we,
   input  logic [CB_ADDR_W-1:0] cb_addr,
   input  logic [REG_W-1:0]     cb_wdata,
   output logic [REG_W-1:0]     cb_rdata,
   output logic                 ds_req_valid,
   input  logic                 ds_req_ready,
   output logic                 ds_req_write,
   output logic [DS_ADDR_W-1:0] ds_req_addr,
   output logic [SZ_W-1:0]      ds_req_size,
   output logic [DS_DATA_W-1:0] ds_req_wdata,
   output logic [NB-1:0]        ds_req_be,
   input  logic                 ds_rsp_valid,
   input  logic [DS_DATA_W-1:0] ds_rsp_rdata
);
   // elaboration-time parameter checks
   if (DS_DATA_W % 8 != 0 || DS_DATA_W < 8 || DS_DATA_W > 64) begin : g_bad_dw
      $error("DS_DATA_W must be a whole number of bytes between 8 and 64");
   end
   if (DS_ADDR_W < 3 || DS_ADDR_W > 32) begin : g_bad_aw
      $error("DS_ADDR_W must lie between 3 and 32");
   end
   if (CB_ADDR_W < 10) begin : g_bad_cw
      $error("CB_ADDR_W too narrow for the register offsets");
   end

   localparam logic [OW-1:0] K_BASE = OFS_BASE[OW-1:0];
   localparam logic [OW-1:0] K_CMD  = OFS_CMD[OW-1:0];
   localparam logic [OW-1:0] K_DATA = OFS_DATA[OW-1:0];
   localparam logic [OW-1:0] K_STAT = OFS_STAT[OW-1:0];

   logic [OW-1:0]        ofs;
   logic                 unused_lo;
   logic                 wr_cmd, wr_dat;
   logic [REG_W-1:0]     cmd_q, data_q, eff_cmd, rd_placed;
   cmd_fields_t          fld;
   logic                 size_ok, busy, rd_done;
   logic                 launch_rd, launch_wr;
   logic [DS_DATA_W-1:0] wr_bytes;
   logic [NB-1:0]        wr_be;

   assign ofs       = cb_addr[CB_ADDR_W-1:3];
   assign unused_lo = ^cb_addr[2:0];
   assign wr_cmd    = cb_valid && cb_we && (ofs == K_CMD);
   assign wr_dat    = cb_valid && cb_we && (ofs == K_DATA);

   // a command write is decoded as it arrives; a data write uses the stored command
   assign eff_cmd = wr_cmd ? cb_wdata : cmd_q;

   lpce_cmd_decode #(.MAX_BYTES(NB)) u_dec (
      .cmd_word (eff_cmd),
      .fields   (fld),
      .size_ok  (size_ok)
   );

   assign launch_rd = wr_cmd &&  fld.is_read && size_ok && !busy;
   assign launch_wr = wr_dat && !fld.is_read && size_ok && !busy;

   lpce_lane_align #(.DS_DATA_W(DS_DATA_W)) u_align (
      .rd_src    (ds_rsp_rdata),
      .rd_size   (SIZE_FLD_W'(ds_req_size)),
      .rd_off    (ds_req_addr[2:0]),
      .rd_placed (rd_placed),
      .wr_src    (cb_wdata),
      .wr_size   (fld.size),
      .wr_off    (fld.addr[2:0]),
      .wr_bytes  (wr_bytes),
      .wr_be     (wr_be)
   );

   lpce_xfer_fsm #(
      .DS_ADDR_W (DS_ADDR_W),
      .DS_DATA_W (DS_DATA_W),
      .SZ_W      (SZ_W)
   ) u_fsm (
      .clk          (clk),
      .rst_n        (rst_n),
      .launch       (launch_rd || launch_wr),
      .launch_write (launch_wr),
      .launch_addr  (fld.addr[DS_ADDR_W-1:0]),
      .launch_size  (SZ_W'(fld.size)),
      .launch_wdata (wr_bytes),
      .launch_be    (wr_be),
      .req_valid    (ds_req_valid),
      .req_ready    (ds_req_ready),
      .req_write    (ds_req_write),
      .req_addr     (ds_req_addr),
      .req_size     (ds_req_size),
      .req_wdata    (ds_req_wdata),
      .req_be       (ds_req_be),
      .rsp_valid    (ds_rsp_valid),
      .busy         (busy),
      .rd_done      (rd_done)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cmd_q  <= '0;
         data_q <= '0;
      end else begin
         if (wr_cmd) cmd_q <= cb_wdata;
         if (rd_done)     data_q <= rd_placed;
         else if (wr_dat) data_q <= cb_wdata;
      end
   end

   always_comb begin
      unique case (ofs)
         K_BASE:  cb_rdata = '0;
         K_CMD:   cb_rdata = cmd_q;
         K_DATA:  cb_rdata = data_q;
         K_STAT:  cb_rdata = {~busy, {(REG_W-1){1'b0}}};
         default: cb_rdata = '0;
      endcase
   end
endmodule

// File: rtl/lpce_chk.sv
module lpce_chk #(
   parameter int OW        = 13,
   parameter int DS_ADDR_W = 32,
   parameter int DS_DATA_W = 32,
   parameter int SZ_W      = 3,
   parameter int OFS_BASE  = 'h40,
   parameter int OFS_STAT  = 'h43
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic                   cb_valid,
   input logic                   cb_we,
   input logic [OW-1:0]          cb_ofs,
   input logic [63:0]            cb_rdata,
   input logic                   ds_req_valid,
   input logic                   ds_req_ready,
   input logic                   ds_req_write,
   input logic [DS_ADDR_W-1:0]   ds_req_addr,
   input logic [SZ_W-1:0]        ds_req_size,
   input logic [DS_DATA_W-1:0]   ds_req_wdata,
   input logic [DS_DATA_W/8-1:0] ds_req_be,
   input logic                   busy
);
   localparam logic [OW-1:0] K_BASE = OFS_BASE[OW-1:0];
   localparam logic [OW-1:0] K_STAT = OFS_STAT[OW-1:0];

   p_base_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (cb_valid && !cb_we && cb_ofs == K_BASE) |-> (cb_rdata == 64'h0));

   p_be_match_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (ds_req_valid && ds_req_write) |-> ($countones(ds_req_be) == int'(ds_req_size)));

   p_done_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (cb_valid && !cb_we && cb_ofs == K_STAT) |-> (cb_rdata[63] == !busy));

   p_req_under_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ds_req_valid |-> busy);

   p_launch_from_host_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ds_req_valid) |-> $past(cb_valid && cb_we && !busy));

   p_size_legal_r9: assert property (@(posedge clk) disable iff (!rst_n)
      ds_req_valid |-> ($countones(ds_req_size) == 1 && int'(ds_req_size) <= DS_DATA_W / 8));

   p_req_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (ds_req_valid && !ds_req_ready) |=> (ds_req_valid && $stable(ds_req_addr)
         && $stable(ds_req_size) && $stable(ds_req_write) && $stable(ds_req_wdata)
         && $stable(ds_req_be)));
endmodule

bind lpc_indirect_eng lpce_chk #(
   .OW        (OW),
   .DS_ADDR_W (DS_ADDR_W),
   .DS_DATA_W (DS_DATA_W),
   .SZ_W      (SZ_W),
   .OFS_BASE  (OFS_BASE),
   .OFS_STAT  (OFS_STAT)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .cb_valid     (cb_valid),
   .cb_we        (cb_we),
   .cb_ofs       (cb_addr[CB_ADDR_W-1:3]),
   .cb_rdata     (cb_rdata),
   .ds_req_valid (ds_req_valid),
   .ds_req_ready (ds_req_ready),
   .ds_req_write (ds_req_write),
   .ds_req_addr  (ds_req_addr),
   .ds_req_size  (ds_req_size),
   .ds_req_wdata (ds_req_wdata),
   .ds_req_be    (ds_req_be),
   .busy         (busy)
);

// File: tb/lpc_indirect_eng_tb.sv
`timescale 1ns/1ps
module lpc_indirect_eng_tb;
   localparam logic [15:0] A_BASE = 16'h0200;
   localparam logic [15:0] A_CMD  = 16'h0208;
   localparam logic [15:0] A_DATA = 16'h0210;
   localparam logic [15:0] A_STAT = 16'h0218;
   localparam logic [15:0] A_UNM  = 16'h0120;

   logic        clk = 1'b0, rst_n = 1'b0;
   logic        cb_valid = 1'b0, cb_we = 1'b0;
   logic [15:0] cb_addr = '0;
   logic [63:0] cb_wdata = '0, cb_rdata;
   logic        ds_req_valid, ds_req_ready = 1'b0, ds_req_write;
   logic [31:0] ds_req_addr, ds_req_wdata;
   logic [2:0]  ds_req_size;
   logic [3:0]  ds_req_be;
   logic        ds_rsp_valid = 1'b0;
   logic [31:0] ds_rsp_rdata = '0;

   int vectors = 0, errors = 0;

   always #2.5 clk = ~clk;

   lpc_indirect_eng u_dut (
      .clk(clk), .rst_n(rst_n), .cb_valid(cb_valid), .cb_we(cb_we),
      .cb_addr(cb_addr), .cb_wdata(cb_wdata), .cb_rdata(cb_rdata),
      .ds_req_valid(ds_req_valid), .ds_req_ready(ds_req_ready),
      .ds_req_write(ds_req_write), .ds_req_addr(ds_req_addr),
      .ds_req_size(ds_req_size), .ds_req_wdata(ds_req_wdata),
      .ds_req_be(ds_req_be), .ds_rsp_valid(ds_rsp_valid),
      .ds_rsp_rdata(ds_rsp_rdata)
   );

   task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      vectors++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [63:0] mk_cmd(input bit rd, input int n, input logic [31:0] a);
      return {rd, 4'h0, 7'(n), 20'h0, a};
   endfunction

   function automatic logic [63:0] exp_place(input logic [31:0] v, input int n, input int off);
      logic [31:0] m = (n >= 4) ? 32'hffff_ffff : ((32'h1 << (8 * n)) - 1);
      logic [63:0] lj = {v & m, 32'h0};
      lj = lj << (8 * (4 - n));
      return lj >> (8 * off);
   endfunction

   function automatic logic [31:0] exp_wdata(input logic [63:0] d, input int n, input int off);
      logic [63:0] t = d << (8 * off);
      return 32'(t >> (64 - 8 * n));
   endfunction

   // all tasks start and end at a falling edge
   task automatic cb_write(input logic [15:0] a, input logic [63:0] d);
      cb_valid = 1'b1; cb_we = 1'b1; cb_addr = a; cb_wdata = d;
      @(posedge clk); @(negedge clk);
      cb_valid = 1'b0; cb_we = 1'b0;
   endtask

   task automatic cb_read(input logic [15:0] a, output logic [63:0] d);
      cb_valid = 1'b1; cb_we = 1'b0; cb_addr = a;
      #1 d = cb_rdata;
      cb_valid = 1'b0;
   endtask

   task automatic idle(input int c);
      repeat (c) @(negedge clk);
   endtask

   // hold the request for a random time, then accept it
   task automatic accept_req;
      int w = int'($urandom_range(0, 3));
      logic [31:0] a0 = ds_req_addr;
      for (int i = 0; i < w; i++) begin
         idle(1);
         chk(ds_req_valid && ds_req_addr == a0, "R10 request held", {63'h0, ds_req_valid}, 64'h1);
      end
      ds_req_ready = 1'b1;
      @(posedge clk); @(negedge clk);
      ds_req_ready = 1'b0;
   endtask

   task automatic respond(input logic [31:0] v);
      ds_rsp_valid = 1'b1; ds_rsp_rdata = v;
      @(posedge clk); @(negedge clk);
      ds_rsp_valid = 1'b0; ds_rsp_rdata = '0;
   endtask

   task automatic run_read(input logic [31:0] a, input int n, input bit poke);
      logic [63:0] r, pk;
      logic [31:0] rv = $urandom;
      cb_write(A_CMD, mk_cmd(1'b1, n, a));
      chk(ds_req_valid && !ds_req_write && ds_req_addr == a && int'(ds_req_size) == n,
          "R3 read request", {ds_req_valid, ds_req_write, ds_req_size, ds_req_addr},
          {1'b1, 1'b0, 3'(n), a});
      cb_read(A_STAT, r);
      chk(r == 64'h0, "R7 done low while busy", r, 64'h0);
      accept_req();
      pk = mk_cmd(1'b1, 4, $urandom);
      if (poke) begin
         cb_write(A_CMD, pk);
         cb_write(A_DATA, {$urandom, $urandom});
         chk(!ds_req_valid, "R8 no launch while busy", {63'h0, ds_req_valid}, 64'h0);
      end
      idle(int'($urandom_range(0, 2)));
      respond(rv);
      cb_read(A_STAT, r);
      chk(r == 64'h8000_0000_0000_0000, "R7 done after response", r, 64'h8000_0000_0000_0000);
      cb_read(A_DATA, r);
      chk(r == exp_place(rv, n, int'(a[2:0])), "R5 read lane placement", r, exp_place(rv, n, int'(a[2:0])));
      if (poke) begin
         cb_read(A_CMD, r);
         chk(r == pk, "R8 command stored while busy", r, pk);
         idle(3);
         chk(!ds_req_valid, "R8 no late launch", {63'h0, ds_req_valid}, 64'h0);
      end
   endtask

   task automatic run_write(input logic [31:0] a, input int n, input logic [63:0] d);
      logic [63:0] r;
      logic [31:0] ew = exp_wdata(d, n, int'(a[2:0]));
      logic [3:0]  eb = 4'((1 << n) - 1);
      cb_write(A_CMD, mk_cmd(1'b0, n, a));
      chk(!ds_req_valid, "R4 write command alone starts nothing", {63'h0, ds_req_valid}, 64'h0);
      cb_write(A_DATA, d);
      chk(ds_req_valid && ds_req_write && ds_req_addr == a && int'(ds_req_size) == n,
          "R4 write request", {ds_req_valid, ds_req_write, ds_req_size, ds_req_addr},
          {1'b1, 1'b1, 3'(n), a});
      chk(ds_req_wdata == ew && ds_req_be == eb, "R6 write lanes and enables",
          {ds_req_be, ds_req_wdata}, {eb, ew});
      accept_req();
      idle(int'($urandom_range(0, 2)));
      respond($urandom);
      cb_read(A_DATA, r);
      chk(r == d, "R4 data register after write", r, d);
      cb_read(A_STAT, r);
      chk(r[63], "R7 done after write", r, 64'h8000_0000_0000_0000);
   endtask

   initial begin : main
      logic [63:0] r, keep;
      void'($urandom(32'h5eed_0c1e));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      idle(1);

      // reset state and register map
      cb_read(A_CMD, r);  chk(r == 0, "R1 reset command", r, 0);
      cb_read(A_DATA, r); chk(r == 0, "R1 reset data", r, 0);
      cb_read(A_STAT, r); chk(r == 64'h8000_0000_0000_0000, "R7 reset status", r, 64'h8000_0000_0000_0000);
      cb_write(A_BASE, 64'hdead_beef_1234_5678);
      cb_read(A_BASE, r); chk(r == 0, "R1 base reads zero", r, 0);
      cb_write(A_UNM, 64'h1111_2222_3333_4444);
      cb_read(A_UNM, r);  chk(r == 0, "R1 unmapped reads zero", r, 0);
      chk(!ds_req_valid, "R1 ignored writes start nothing", {63'h0, ds_req_valid}, 0);
      cb_write(A_STAT, 64'h0);
      cb_read(A_STAT, r); chk(r == 64'h8000_0000_0000_0000, "R7 status write ignored", r, 64'h8000_0000_0000_0000);
      cb_write(A_CMD, 64'h7a5a_0000_cafe_f00d);
      cb_read(A_CMD, r);  chk(r == 64'h7a5a_0000_cafe_f00d, "R2 command readback", r, 64'h7a5a_0000_cafe_f00d);
      chk(!ds_req_valid, "R9 size 0x25 launches nothing", {63'h0, ds_req_valid}, 0);

      // every legal size at every sector offset
      for (int s = 0; s < 3; s++) begin
         for (int o = 0; o < 8; o++) begin
            run_read({24'h0012_34, 5'h0, 3'(o)} + 32'h100 * s, 1 << s, 1'b0);
            run_write({24'h00ab_cd, 5'h0, 3'(o)}, 1 << s, {$urandom, $urandom});
         end
      end

      // unsupported sizes: no transfer, data unchanged
      cb_read(A_DATA, keep);
      cb_write(A_CMD, mk_cmd(1'b1, 3, 32'h40));
      chk(!ds_req_valid, "R9 read size 3 ignored", {63'h0, ds_req_valid}, 0);
      cb_read(A_STAT, r); chk(r[63], "R9 done stays high", r, 64'h8000_0000_0000_0000);
      cb_read(A_DATA, r); chk(r == keep, "R9 data unchanged", r, keep);
      cb_write(A_CMD, mk_cmd(1'b0, 8, 32'h40));
      cb_write(A_DATA, 64'h0102_0304_0506_0708);
      chk(!ds_req_valid, "R9 write size 8 ignored", {63'h0, ds_req_valid}, 0);

      // data write while the command is a read
      cb_write(A_CMD, mk_cmd(1'b1, 0, 32'h0));
      cb_write(A_DATA, 64'hfeed_face_0bad_cafe);
      chk(!ds_req_valid, "R4 data write under read command", {63'h0, ds_req_valid}, 0);
      cb_read(A_DATA, r); chk(r == 64'hfeed_face_0bad_cafe, "R4 data readback", r, 64'hfeed_face_0bad_cafe);

      // random mix, some with host writes while busy
      for (int i = 0; i < 60; i++) begin
         int n = 1 << $urandom_range(0, 2);
         logic [31:0] a = $urandom;
         if ($urandom_range(0, 1) == 1) run_read(a, n, $urandom_range(0, 2) == 0);
         else run_write(a, n, {$urandom, $urandom});
      end

      $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired actual=hang expected=completion");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end
endmodule